// File: doc/BRIEF.md
# Snooping Test-and-Set Lock Agent

This block sits between one processor and a shared snooping bus. It carries out lock acquisition for its processor so that test-and-set transactions that could not succeed never reach the bus. When the processor asks to acquire the lock at some address, the agent first finds out the lock's current value. It uses a one-entry local copy of the lock line when that copy is valid. Otherwise it gets the value through a read-miss transaction, or takes it from another agent's read-miss data seen on the bus. A busy value ends the attempt at once, and no test-and-set is issued. A free value makes the agent request the bus for a test-and-set.

While that request waits for a grant, the agent watches the bus. If another agent's test-and-set to the same address succeeds first, the agent withdraws its request in that same cycle and reports an abort. The local copy follows bus traffic. A snooped write that changes the stored value invalidates it, and so does another agent's successful test-and-set. A test-and-set that finds the lock already busy changes nothing, so it leaves the copy valid.

The bench plays the part of the bus and the memory. Every bus transaction, the agent's own included, shows up on the snoop inputs. For a test-and-set, the snooped data is the lock value from before the operation. A lock value of all zeros means free, and any other value means busy. A successful test-and-set stores the value 1.

Top module: `snoop_tas_agent`

## Requirements
- R1: After reset, `bus_req` and `acq_done` are 0 and the local copy is invalid, so the first acquire always goes to the bus.
- R2: `acq_done` is a one-cycle pulse, registered one clock after the deciding event. `acq_result` is valid with it and encoded 2'b01 acquired, 2'b10 failed (lock busy), 2'b11 aborted by snoop.
- R3: On an acquire whose address misses the local copy, the agent raises `bus_req` with `cmd_op` = 2'b00 (read miss) and `cmd_addr` set to the lock address. After the read is issued, it waits with `bus_req` low.
- R4: While the read-miss request is pending, a snooped read miss by another agent (`snp_own`=0, `snp_op`=2'b00) to the same address supplies the value. `bus_req` drops in that same cycle, and no read is issued.
- R5: A busy value obtained from the bus ends the attempt with result 2'b10, and no test-and-set is requested.
- R6: A free value makes the agent request the bus with `cmd_op` = 2'b01 (test-and-set). If its own snooped test-and-set returns old value 0, the result is 2'b01 and the copy holds the value 1.
- R7: While the test-and-set request is pending, another agent's test-and-set to the same address with old value 0 drops `bus_req` in that same cycle, suppresses `cmd_valid`, and gives result 2'b11 one cycle later.
- R8: Another agent's test-and-set that finds the lock busy (old value nonzero) neither aborts a pending request nor invalidates the local copy.
- R9: An acquire that hits a valid copy holding a busy value returns 2'b10 on the next cycle, and `bus_req` never rises.
- R10: A snooped write (`snp_op` = 2'b10) to the copied address invalidates the copy only if its data differs from the stored value.
- R11: An acquire request is taken only while no attempt is in progress. A request during an attempt is ignored, and the attempt keeps its address.
- R12: `cmd_valid` is high only in a cycle where `bus_req` and `bus_grant` are both high. A grant with no request does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | 1 | Processor asks to acquire the lock at `acq_addr` |
| acq_addr | input | AW | Lock address |
| acq_done | output | 1 | One-cycle completion pulse |
| acq_result | output | 2 | 01 acquired, 10 busy, 11 aborted |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| cmd_valid | output | 1 | Agent drives a transaction this cycle |
| cmd_op | output | 2 | 00 read miss, 01 test-and-set, 11 none |
| cmd_addr | output | AW | Address of the attempt in progress |
| snp_valid | input | 1 | A transaction is visible on the bus |
| snp_own | input | 1 | The visible transaction is this agent's |
| snp_op | input | 2 | 00 read miss, 01 test-and-set, 10 write |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Read data, old value for test-and-set, or written data |

## Verification
Acquires are tried four ways: with a copy miss served by the agent's own read, with a miss served by another agent's read miss, with a hit on a busy copy, and with a free value followed by a test-and-set. These separate the path that never touches the bus from the path that reads the bus, and the path that takes its value from another agent's read. Snooped test-and-sets by other agents are sent with free and with busy old values during a pending request. This shows whether the agent aborts only on a real win. Writes are sent with the same value and with a changed value, to show whether the copy is invalidated only on a real change. A request raised mid-attempt and a grant raised while idle check that neither disturbs the bus.

// File: rtl/tas_agent_pkg.sv
`timescale 1ns/1ps
package tas_agent_pkg;

    typedef enum logic [1:0] {
        OP_RDMISS = 2'b00,
        OP_TAS    = 2'b01,
        OP_WRITE  = 2'b10,
        OP_NONE   = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'b00,
        RES_GOT   = 2'b01,
        RES_BUSY  = 2'b10,
        RES_ABORT = 2'b11
    } acq_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_TAS_REQ,
        ST_TAS_WAIT
    } agent_st_e;

    typedef struct packed {
        logic oth_rd;   // another agent's read miss
        logic own_rd;   // our read miss completing
        logic own_tas;  // our test-and-set completing
        logic oth_win;  // another agent's test-and-set that found the lock free
        logic wr;       // any write
    } snp_ev_t;

endpackage

// File: rtl/tas_snoop_dec.sv
`timescale 1ns/1ps
module tas_snoop_dec
    import tas_agent_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          snp_valid,
    input  logic          snp_own,
    input  logic [1:0]    snp_op,
    input  logic [DW-1:0] snp_data,
    output snp_ev_t       ev,
    output logic          data_free
);

    always_comb begin
        data_free  = (snp_data == '0);
        ev         = '0;
        ev.oth_rd  = snp_valid && !snp_own && (snp_op == OP_RDMISS);
        ev.own_rd  = snp_valid &&  snp_own && (snp_op == OP_RDMISS);
        ev.own_tas = snp_valid &&  snp_own && (snp_op == OP_TAS);
        ev.oth_win = snp_valid && !snp_own && (snp_op == OP_TAS) && data_free;
        ev.wr      = snp_valid && (snp_op == OP_WRITE);
    end

endmodule

// File: rtl/tas_line_copy.sv
`timescale 1ns/1ps
module tas_line_copy #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ev,
    input  logic          win_ev,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    output logic          c_valid,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data,
    output logic          inv_now
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d  = line_q;
        // only a real change of value kills the copy
        inv_now = line_q.valid && (snp_addr == line_q.addr) &&
                  ((wr_ev && (snp_data != line_q.data)) || win_ev);
        if (inv_now) line_d.valid = 1'b0;
        if (fill_en) begin
            line_d.valid = 1'b1;
            line_d.addr  = fill_addr;
            line_d.data  = fill_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign c_valid = line_q.valid;
    assign c_addr  = line_q.addr;
    assign c_data  = line_q.data;

endmodule

// File: rtl/tas_agent_ctrl.sv
`timescale 1ns/1ps
module tas_agent_ctrl
    import tas_agent_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            DW         = 8,
    parameter logic [DW-1:0] LOCKED_VAL = 'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_req,
    input  logic [AW-1:0] acq_addr,
    input  logic          oth_rd,
    input  logic          own_rd,
    input  logic          own_tas,
    input  logic          oth_win,
    input  logic          data_free,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    input  logic          c_valid,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_data,
    input  logic          inv_now,
    input  logic          bus_grant,
    output logic          acq_done,
    output logic [1:0]    acq_result,
    output logic          bus_req,
    output logic          cmd_valid,
    output logic [1:0]    cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic          fill_en,
    output logic [AW-1:0] fill_addr,
    output logic [DW-1:0] fill_data
);

    typedef struct packed {
        agent_st_e     st;
        logic [AW-1:0] addr;
        logic          done;
        logic [1:0]    res;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  hit, kill_rd, kill_tas, req;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        hit       = c_valid && !inv_now && (c_addr == acq_addr);
        kill_rd   = (ctl_q.st == ST_RD_REQ)  && oth_rd  && (snp_addr == ctl_q.addr);
        kill_tas  = (ctl_q.st == ST_TAS_REQ) && oth_win && (snp_addr == ctl_q.addr);
        // withdraw in the very cycle the deciding transaction is seen
        req       = ((ctl_q.st == ST_RD_REQ) || (ctl_q.st == ST_TAS_REQ)) &&
                    !kill_rd && !kill_tas;
        fill_en   = 1'b0;
        fill_data = snp_data;
        case (ctl_q.st)
            ST_IDLE: begin
                if (acq_req) begin
                    ctl_d.addr = acq_addr;
                    if (!hit) begin
                        ctl_d.st = ST_RD_REQ;
                    end else if (c_data != '0) begin
                        ctl_d.done = 1'b1;
                        ctl_d.res  = RES_BUSY;
                    end else begin
                        ctl_d.st = ST_TAS_REQ;
                    end
                end
            end
            ST_RD_REQ, ST_RD_WAIT: begin
                if (kill_rd || ((ctl_q.st == ST_RD_WAIT) && own_rd)) begin
                    fill_en = 1'b1;
                    if (data_free) begin
                        ctl_d.st = ST_TAS_REQ;
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.res  = RES_BUSY;
                    end
                end else if ((ctl_q.st == ST_RD_REQ) && req && bus_grant) begin
                    ctl_d.st = ST_RD_WAIT;
                end
            end
            ST_TAS_REQ: begin
                if (kill_tas) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.res  = RES_ABORT;
                end else if (req && bus_grant) begin
                    ctl_d.st = ST_TAS_WAIT;
                end
            end
            ST_TAS_WAIT: begin
                if (own_tas) begin
                    fill_en    = 1'b1;
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                    if (data_free) begin
                        ctl_d.res = RES_GOT;
                        fill_data = LOCKED_VAL;
                    end else begin
                        ctl_d.res = RES_BUSY;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, addr: '0, done: 1'b0, res: 2'b00};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (ctl_q.st)
            ST_RD_REQ, ST_RD_WAIT:   cmd_op = OP_RDMISS;
            ST_TAS_REQ, ST_TAS_WAIT: cmd_op = OP_TAS;
            default:                 cmd_op = OP_NONE;
        endcase
    end

    assign bus_req    = req;
    assign cmd_valid  = req && bus_grant;
    assign cmd_addr   = ctl_q.addr;
    assign fill_addr  = ctl_q.addr;
    assign acq_done   = ctl_q.done;
    assign acq_result = ctl_q.res;

endmodule

// File: rtl/snoop_tas_agent.sv
`timescale 1ns/1ps
module snoop_tas_agent
    import tas_agent_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            DW         = 8,
    parameter logic [DW-1:0] LOCKED_VAL = 'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_req,
    input  logic [AW-1:0] acq_addr,
    output logic          acq_done,
    output logic [1:0]    acq_result,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          cmd_valid,
    output logic [1:0]    cmd_op,
    output logic [AW-1:0] cmd_addr,
    input  logic          snp_valid,
    input  logic          snp_own,
    input  logic [1:0]    snp_op,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data
);

    snp_ev_t       ev;
    logic          data_free;
    logic          c_valid, inv_now, fill_en;
    logic [AW-1:0] c_addr, fill_addr;
    logic [DW-1:0] c_data, fill_data;

    tas_snoop_dec #(.DW(DW)) u_dec (
        .snp_valid (snp_valid),
        .snp_own   (snp_own),
        .snp_op    (snp_op),
        .snp_data  (snp_data),
        .ev        (ev),
        .data_free (data_free)
    );

    tas_line_copy #(.AW(AW), .DW(DW)) u_copy (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ev     (ev.wr),
        .win_ev    (ev.oth_win),
        .snp_addr  (snp_addr),
        .snp_data  (snp_data),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .c_valid   (c_valid),
        .c_addr    (c_addr),
        .c_data    (c_data),
        .inv_now   (inv_now)
    );

    tas_agent_ctrl #(.AW(AW), .DW(DW), .LOCKED_VAL(LOCKED_VAL)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_req    (acq_req),
        .acq_addr   (acq_addr),
        .oth_rd     (ev.oth_rd),
        .own_rd     (ev.own_rd),
        .own_tas    (ev.own_tas),
        .oth_win    (ev.oth_win),
        .data_free  (data_free),
        .snp_addr   (snp_addr),
        .snp_data   (snp_data),
        .c_valid    (c_valid),
        .c_addr     (c_addr),
        .c_data     (c_data),
        .inv_now    (inv_now),
        .bus_grant  (bus_grant),
        .acq_done   (acq_done),
        .acq_result (acq_result),
        .bus_req    (bus_req),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .fill_en    (fill_en),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data)
    );

endmodule

// File: rtl/tas_agent_chk.sv
`timescale 1ns/1ps
module tas_agent_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acq_done,
    input logic [1:0]    acq_result,
    input logic          bus_req,
    input logic          bus_grant,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [AW-1:0] cmd_addr,
    input logic          snp_valid,
    input logic          snp_own,
    input logic [1:0]    snp_op,
    input logic [AW-1:0] snp_addr,
    input logic [DW-1:0] snp_data
);

    logic rival_win;
    assign rival_win = snp_valid && !snp_own && (snp_op == 2'b01) &&
                       (snp_addr == cmd_addr) && (snp_data == '0);

    p_cmd_needs_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (bus_req && bus_grant));

    p_result_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> (acq_result != 2'b00));

    p_done_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> !bus_req);

    p_read_then_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00) |=> (!bus_req && !acq_done));

    p_tas_then_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b01) |=> (!bus_req && !acq_done));

    p_abort_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_req && !bus_grant && cmd_op == 2'b01) && rival_win) |-> !bus_req);

    p_abort_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_req && !bus_grant && cmd_op == 2'b01) && rival_win) |=>
            (acq_done && acq_result == 2'b11));

endmodule

bind snoop_tas_agent tas_agent_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_done   (acq_done),
    .acq_result (acq_result),
    .bus_req    (bus_req),
    .bus_grant  (bus_grant),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .snp_valid  (snp_valid),
    .snp_own    (snp_own),
    .snp_op     (snp_op),
    .snp_addr   (snp_addr),
    .snp_data   (snp_data)
);

// File: tb/sim_snoop_tas_agent.sv
`timescale 1ns/1ps
module sim_snoop_tas_agent;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_req = 1'b0;
    logic [AW-1:0] acq_addr = '0;
    logic          acq_done;
    logic [1:0]    acq_result;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic          cmd_valid;
    logic [1:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic          snp_valid = 1'b0;
    logic          snp_own = 1'b0;
    logic [1:0]    snp_op = 2'b11;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    snoop_tas_agent #(.AW(AW), .DW(DW)) u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            m_phase = 0;  // 0 idle 1 read-req 2 read-wait 3 tas-req 4 tas-wait
    logic [AW-1:0] m_addr = '0;
    bit            m_cv = 0;
    logic [AW-1:0] m_ca = '0;
    logic [DW-1:0] m_cd = '0;
    bit            m_done = 0;
    logic [1:0]    m_res = 2'b00;

    always @(negedge clk) begin
        #3;
        if (!rst_n) begin
            m_phase = 0; m_cv = 0; m_done = 0; m_res = 2'b00; m_addr = '0;
        end else begin
            bit free, other, ord, otw, wr, ownrd, owntas, kill, ereq, ecmd, inv, fill, hit, nd;
            logic [DW-1:0] fdata;
            free   = (snp_data == 0);
            other  = snp_valid && !snp_own;
            ord    = other && snp_op == 2'b00;
            otw    = other && snp_op == 2'b01 && free;
            wr     = snp_valid && snp_op == 2'b10;
            ownrd  = snp_valid && snp_own && snp_op == 2'b00;
            owntas = snp_valid && snp_own && snp_op == 2'b01;
            kill   = (m_phase == 1 && ord && snp_addr == m_addr) ||
                     (m_phase == 3 && otw && snp_addr == m_addr);
            ereq   = (m_phase == 1 || m_phase == 3) && !kill;
            ecmd   = ereq && bus_grant;
            check("model bus_req", bus_req, ereq);
            check("model cmd_valid", cmd_valid, ecmd);
            if (ecmd) begin
                check("model cmd_op", cmd_op, (m_phase == 1) ? 2'b00 : 2'b01);
                check("model cmd_addr", cmd_addr, m_addr);
            end
            check("model acq_done", acq_done, m_done);
            if (m_done) check("model acq_result", acq_result, m_res);
            inv  = m_cv && snp_addr == m_ca && ((wr && snp_data != m_cd) || otw);
            hit  = m_cv && !inv && m_ca == acq_addr;
            fill = 0; fdata = snp_data; nd = 0;
            case (m_phase)
                0: if (acq_req) begin
                       m_addr = acq_addr;
                       if (!hit) m_phase = 1;
                       else if (m_cd != 0) begin nd = 1; m_res = 2'b10; end
                       else m_phase = 3;
                   end
                1, 2: if (kill || (m_phase == 2 && ownrd)) begin
                       fill = 1;
                       if (free) m_phase = 3;
                       else begin m_phase = 0; nd = 1; m_res = 2'b10; end
                   end else if (m_phase == 1 && ecmd) m_phase = 2;
                3: if (kill) begin m_phase = 0; nd = 1; m_res = 2'b11; end
                   else if (ecmd) m_phase = 4;
                default: if (owntas) begin
                       fill = 1; m_phase = 0; nd = 1;
                       if (free) begin m_res = 2'b01; fdata = 1; end
                       else m_res = 2'b10;
                   end
            endcase
            if (inv) m_cv = 0;
            if (fill) begin m_cv = 1; m_ca = m_addr; m_cd = fdata; end
            m_done = nd;
        end
    end

    // drive one cycle of inputs; returns at the sampling point of that cycle
    task automatic step(input logic rq, input logic [AW-1:0] ra, input logic g,
                        input logic sv, input logic so, input logic [1:0] sop,
                        input logic [AW-1:0] sa, input logic [DW-1:0] sd);
        @(negedge clk);
        acq_req = rq; acq_addr = ra; bus_grant = g;
        snp_valid = sv; snp_own = so; snp_op = sop; snp_addr = sa; snp_data = sd;
        #3;
    endtask

    task automatic idle();
        step(0, '0, 0, 0, 0, 2'b11, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        check("R1 bus_req after reset", bus_req, 0);
        check("R1 acq_done after reset", acq_done, 0);

        // R3 / R6: miss, own read returns free, own test-and-set wins
        step(1, 16'h5, 0, 0, 0, 2'b11, 0, 0);
        step(0, 0, 1, 0, 0, 2'b11, 0, 0);
        check("R3 read request", bus_req, 1);
        check("R3 read issued", cmd_valid, 1);
        check("R3 read op", cmd_op, 2'b00);
        check("R3 read addr", cmd_addr, 16'h5);
        step(0, 0, 0, 1, 1, 2'b00, 16'h5, 8'h0);
        idle();
        check("R12 no grant no cmd", cmd_valid, 0);
        check("R6 tas request", bus_req, 1);
        step(0, 0, 1, 0, 0, 2'b11, 0, 0);
        check("R6 tas op", cmd_op, 2'b01);
        step(0, 0, 0, 1, 1, 2'b01, 16'h5, 8'h0);
        idle();
        check("R6 done", acq_done, 1);
        check("R6 acquired", acq_result, 2'b01);
        idle();
        check("R2 done pulse ends", acq_done, 0);

        // R9: hit on busy copy, no bus
        step(1, 16'h5, 0, 0, 0, 2'b11, 0, 0);
        idle();
        check("R9 fast fail", acq_result, 2'b10);
        check("R9 fast done", acq_done, 1);
        check("R9 no bus", bus_req, 0);

        // R10: same-value write keeps copy, changed-value write drops it
        step(0, 0, 0, 1, 0, 2'b10, 16'h5, 8'h1);
        step(1, 16'h5, 0, 0, 0, 2'b11, 0, 0);
        idle();
        check("R10 same value kept", acq_result, 2'b10);
        check("R10 kept no bus", bus_req, 0);
        step(0, 0, 0, 1, 0, 2'b10, 16'h5, 8'h0);
        step(1, 16'h5, 0, 0, 0, 2'b11, 0, 0);
        idle();
        check("R10 changed value invalidates", bus_req, 1);

        // R4: another agent's read miss supplies the value
        step(0, 0, 1, 1, 0, 2'b00, 16'h5, 8'h0);
        check("R4 request withdrawn", bus_req, 0);
        check("R4 no read issued", cmd_valid, 0);
        idle();
        check("R4 tas follows", cmd_op, 2'b01);

        // R7: rival wins while waiting
        step(0, 0, 1, 1, 0, 2'b01, 16'h5, 8'h0);
        check("R7 withdrawn", bus_req, 0);
        check("R7 no tas", cmd_valid, 0);
        idle();
        check("R7 aborted", acq_result, 2'b11);
        check("R7 done", acq_done, 1);

        // R5: busy value from own read
        step(1, 16'h9, 0, 0, 0, 2'b11, 0, 0);
        step(0, 0, 1, 0, 0, 2'b11, 0, 0);
        step(0, 0, 0, 1, 1, 2'b00, 16'h9, 8'h3);
        idle();
        check("R5 busy fail", acq_result, 2'b10);
        check("R5 no tas request", bus_req, 0);

        // R8: rival's failing test-and-set neither aborts nor invalidates
        step(1, 16'hC, 0, 0, 0, 2'b11, 0, 0);
        step(0, 0, 1, 0, 0, 2'b11, 0, 0);
        step(0, 0, 0, 1, 1, 2'b00, 16'hC, 8'h0);
        step(0, 0, 0, 1, 0, 2'b01, 16'hC, 8'h3);
        check("R8 not aborted", bus_req, 1);
        step(0, 0, 1, 0, 0, 2'b11, 0, 0);
        step(0, 0, 0, 1, 1, 2'b01, 16'hC, 8'h0);
        idle();
        check("R8 later acquired", acq_result, 2'b01);
        step(0, 0, 0, 1, 0, 2'b01, 16'hC, 8'h1);
        step(1, 16'hC, 0, 0, 0, 2'b11, 0, 0);
        idle();
        check("R8 copy kept", acq_result, 2'b10);
        check("R8 copy kept no bus", bus_req, 0);

        // R11: request during an attempt is ignored
        step(1, 16'h14, 0, 0, 0, 2'b11, 0, 0);
        step(1, 16'h15, 0, 0, 0, 2'b11, 0, 0);
        step(0, 0, 1, 0, 0, 2'b11, 0, 0);
        check("R11 addr kept", cmd_addr, 16'h14);
        step(0, 0, 0, 1, 1, 2'b00, 16'h14, 8'h5);
        idle();
        check("R11 attempt completes", acq_result, 2'b10);

        // R12: grant while idle
        step(0, 0, 1, 0, 0, 2'b11, 0, 0);
        check("R12 idle grant", cmd_valid, 0);
        check("R12 idle no req", bus_req, 0);
        idle();
        idle();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule